// File: doc/BRIEF.md
# Audio Clock Output Generator

The block produces six audio clocks from two timing sources: a master clock recovered by a PLL and a fixed crystal reference. Each source arrives as a single-cycle strobe in the system clock domain. A strobe marks every edge of that source, rising or falling, so the source clock itself completes one period every two strobes. Every output is a registered level built from one shared binary counter. The counter advances on strobes of whichever source is active. A clock at ratio 2^k below the source is the counter's bit k.

The active source follows the PLL lock flag: recovered clock when locked, crystal when unlocked. When the flag changes, the counter restarts from zero. All counter-derived outputs are held low for one frame period of the new source, and then run again in phase. The buffered crystal output has its own two-bit stage, so it keeps running through a switchover.

Each output takes a 2-bit selection. A new selection, including mute, is adopted only while that output is low, so no high phase is ever shortened. In slave mode the primary bit and frame clocks stop driving: their enables go low and their levels are held low.

Top module: `audio_clk_gen`

## Requirements
- R1: When unlocked, `mclk_o` is the crystal source clock divided by 1, 2 or 4 for `xtal_mclk_sel` codes 0, 1 or 2, which means it toggles every 1, 2 or 4 crystal strobes. Code 3 mutes it.
- R2: When locked, `mclk_o` is the PLL source clock divided by 1, 2 or 4 for `pll_mclk_sel` codes 0, 1 or 2. Code 3 mutes it.
- R3: Call the active source's rate flag h (`pll_src_hi` when locked, `xtal_src_hi` otherwise). When locked, the primary bit clock toggles every 2^(2+h) strobes (64fs) and the frame clock every 2^(8+h) strobes (fs). When unlocked, with code s in 0..2, the bit clock toggles every 2^(s+h) strobes and the frame clock every 2^(6+s+h) strobes. Code 3 mutes each of them.
- R4: When locked, the secondary bit clock toggles every 2^(1+s+h) strobes and the secondary frame clock every 2^(7+s+h) strobes, with s taken from `pll_sbclk_sel` and `pll_sfclk_sel` (3 mutes). When unlocked, the secondary clocks follow the crystal primary selections exactly.
- R5: `xclk_o` toggles every 1 or 2 crystal strobes for `xout_sel` codes 0 or 1, and is muted for codes 2 and 3. It is never interrupted by a lock change.
- R6: In slave mode `bclk_oe` and `fclk_oe` are low and `bclk_o` and `fclk_o` are held low. In master mode both enables are high.
- R7: A muted output stays low. A selection change takes effect only at a cycle where that output's current clock is low, so every high phase keeps its full length.
- R8: All counter-derived clocks start low at counter zero. Each frame clock change coincides with a falling edge of the bit clock it pairs with.
- R9: A change of the lock flag holds every counter-derived output low for 2^(9+h) strobes of the new source. Counting then restarts at zero.
- R10: After reset, every clock output is low. One cycle later the enables follow the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_edge | input | 1 | Strobe per edge of the recovered master clock |
| xtal_edge | input | 1 | Strobe per edge of the crystal clock |
| pll_locked | input | 1 | PLL lock flag; selects the active source |
| slave_mode | input | 1 | 1: primary bit/frame clocks are inputs |
| pll_src_hi | input | 1 | Recovered source is 512fs (0: 256fs) |
| xtal_src_hi | input | 1 | Crystal is 24.576 MHz (0: 12.288 MHz) |
| pll_mclk_sel | input | 2 | Master clock divider on PLL path |
| xtal_mclk_sel | input | 2 | Master clock divider on crystal path |
| xtal_bclk_sel | input | 2 | Crystal-path bit clock rate (both bit clocks) |
| xtal_fclk_sel | input | 2 | Crystal-path frame clock rate (both frame clocks) |
| pll_sbclk_sel | input | 2 | Secondary bit clock rate on PLL path |
| pll_sfclk_sel | input | 2 | Secondary frame clock rate on PLL path |
| xout_sel | input | 2 | Crystal output divider |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Primary bit clock |
| bclk_oe | output | 1 | Drive enable of primary bit clock |
| fclk_o | output | 1 | Primary frame clock |
| fclk_oe | output | 1 | Drive enable of primary frame clock |
| sbclk_o | output | 1 | Secondary bit clock |
| sfclk_o | output | 1 | Secondary frame clock |
| xclk_o | output | 1 | Buffered crystal clock |

## Verification
Two events can fall in the same cycle: a pending selection or mute request, and the falling edge of the counter bit that request waits on. The bench raises a request in the middle of a high phase and holds it there. It then checks every strobe that the output keeps its full high phase and switches at the first low. The second coincidence is the final blanking strobe and the restart of the counter. The bench times the blanking window to the exact strobe: every output must be low through the last blanked strobe, and the fastest clock must rise on the very next one.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef logic [1:0] sel_t;
  localparam sel_t SEL_MUTE = 2'd3;

  // crystal output offers only /1 and /2; upper codes mute
  function automatic sel_t xout_map(sel_t s);
    return s[1] ? SEL_MUTE : s;
  endfunction
endpackage

// File: rtl/aclk_chain.sv
module aclk_chain #(
  parameter int FS_LOG = 8,
  parameter int CW     = FS_LOG + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock_i,
  input  logic          pll_edge_i,
  input  logic          xtal_edge_i,
  input  logic          pll_hi_i,
  input  logic          xtal_hi_i,
  output logic [CW-1:0] cnt_o,
  output logic          blank_o,
  output logic          lock_o,
  output logic          hi_o
);
  localparam logic [CW-1:0] LAST_LO = CW'((1 << (FS_LOG + 1)) - 1);
  localparam logic [CW-1:0] LAST_HI = CW'((1 << (FS_LOG + 2)) - 1);

  logic [CW-1:0] cnt_q;
  logic          blank_q, lock_q;
  logic          step_w, hi_w;
  logic [CW-1:0] last_w;

  always_comb begin
    step_w = lock_q ? pll_edge_i : xtal_edge_i;
    hi_w   = lock_q ? pll_hi_i : xtal_hi_i;
    last_w = hi_w ? LAST_HI : LAST_LO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      blank_q <= 1'b0;
      lock_q  <= lock_i;
    end else if (lock_i != lock_q) begin
      lock_q  <= lock_i;
      blank_q <= 1'b1;
      cnt_q   <= '0;
    end else if (step_w) begin
      if (blank_q && cnt_q == last_w) begin
        cnt_q   <= '0;
        blank_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign blank_o = blank_q;
  assign lock_o  = lock_q;
  assign hi_o    = hi_w;

  // R9
  lock_chg_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_i != lock_q) |=> (blank_q && cnt_q == '0));

  // R9
  blank_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(blank_q) |-> (cnt_q == '0));
endmodule

// File: rtl/aclk_gate.sv
module aclk_gate
  import aclk_pkg::*;
#(
  parameter int CW = 11,
  parameter int IW = $clog2(CW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic [IW-1:0] base_i,
  input  sel_t          req_i,
  input  logic          blank_i,
  input  logic          hold_i,
  output logic          clk_o
);
  localparam int EW = 1 << IW;

  sel_t          sel_q;
  logic          clk_q;
  logic [IW-1:0] idx_w;
  logic [EW-1:0] ext_w;
  logic          bit_w;

  always_comb begin
    idx_w = base_i + IW'(sel_q);
    ext_w = EW'(cnt_i);
    bit_w = (sel_q == SEL_MUTE) ? 1'b0 : ext_w[idx_w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_MUTE;
      clk_q <= 1'b0;
    end else begin
      if (blank_i || !bit_w) sel_q <= req_i;
      clk_q <= bit_w & ~hold_i;
    end
  end

  assign clk_o = clk_q;

  // R7
  mute_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_MUTE) |=> !clk_q);

  // R7
  sel_lowphase_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q != $past(sel_q)) |-> ($past(blank_i) || !$past(bit_w)));
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import aclk_pkg::*;
#(
  parameter int FS_LOG  = 8,
  parameter int BPF_LOG = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pll_edge,
  input  logic       xtal_edge,
  input  logic       pll_locked,
  input  logic       slave_mode,
  input  logic       pll_src_hi,
  input  logic       xtal_src_hi,
  input  logic [1:0] pll_mclk_sel,
  input  logic [1:0] xtal_mclk_sel,
  input  logic [1:0] xtal_bclk_sel,
  input  logic [1:0] xtal_fclk_sel,
  input  logic [1:0] pll_sbclk_sel,
  input  logic [1:0] pll_sfclk_sel,
  input  logic [1:0] xout_sel,
  output logic       mclk_o,
  output logic       bclk_o,
  output logic       bclk_oe,
  output logic       fclk_o,
  output logic       fclk_oe,
  output logic       sbclk_o,
  output logic       sfclk_o,
  output logic       xclk_o
);
  localparam int CW    = FS_LOG + 3;
  localparam int IW    = $clog2(CW + 1);
  localparam int NOUT  = 5;
  localparam int XCW   = 2;
  localparam int XIW   = $clog2(XCW + 1);
  localparam int PB    = FS_LOG - BPF_LOG;  // 64fs position
  localparam int XF    = FS_LOG - 2;        // 4fs position on crystal path

  logic [CW-1:0] cnt_w;
  logic          blank_w, lock_w, hi_w;

  aclk_chain #(.FS_LOG(FS_LOG), .CW(CW)) u_chain (
    .clk        (clk),
    .rst        (rst),
    .lock_i     (pll_locked),
    .pll_edge_i (pll_edge),
    .xtal_edge_i(xtal_edge),
    .pll_hi_i   (pll_src_hi),
    .xtal_hi_i  (xtal_src_hi),
    .cnt_o      (cnt_w),
    .blank_o    (blank_w),
    .lock_o     (lock_w),
    .hi_o       (hi_w)
  );

  // output order: mclk, bclk, fclk, sbclk, sfclk
  logic [IW-1:0] base_a [NOUT];
  sel_t          req_a  [NOUT];
  logic          hold_a [NOUT];
  logic          out_a  [NOUT];
  logic [IW-1:0] h_w;

  always_comb begin
    h_w = IW'(hi_w);
    base_a[0] = '0;
    req_a[0]  = lock_w ? pll_mclk_sel : xtal_mclk_sel;
    hold_a[0] = blank_w;
    base_a[1] = lock_w ? IW'(PB) + h_w : h_w;
    req_a[1]  = lock_w ? sel_t'(0) : xtal_bclk_sel;
    hold_a[1] = blank_w | slave_mode;
    base_a[2] = lock_w ? IW'(FS_LOG) + h_w : IW'(XF) + h_w;
    req_a[2]  = lock_w ? sel_t'(0) : xtal_fclk_sel;
    hold_a[2] = blank_w | slave_mode;
    base_a[3] = lock_w ? IW'(PB - 1) + h_w : h_w;
    req_a[3]  = lock_w ? pll_sbclk_sel : xtal_bclk_sel;
    hold_a[3] = blank_w;
    base_a[4] = lock_w ? IW'(FS_LOG - 1) + h_w : IW'(XF) + h_w;
    req_a[4]  = lock_w ? pll_sfclk_sel : xtal_fclk_sel;
    hold_a[4] = blank_w;
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    aclk_gate #(.CW(CW), .IW(IW)) u_gate (
      .clk    (clk),
      .rst    (rst),
      .cnt_i  (cnt_w),
      .base_i (base_a[g]),
      .req_i  (req_a[g]),
      .blank_i(blank_w),
      .hold_i (hold_a[g]),
      .clk_o  (out_a[g])
    );
  end

  // crystal output stage, independent of lock
  logic [XCW-1:0] xcnt_q;
  always_ff @(posedge clk) begin
    if (rst)            xcnt_q <= '0;
    else if (xtal_edge) xcnt_q <= xcnt_q + 1'b1;
  end

  aclk_gate #(.CW(XCW), .IW(XIW)) u_xgate (
    .clk    (clk),
    .rst    (rst),
    .cnt_i  (xcnt_q),
    .base_i ('0),
    .req_i  (xout_map(xout_sel)),
    .blank_i(1'b0),
    .hold_i (1'b0),
    .clk_o  (xclk_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_oe <= 1'b0;
      fclk_oe <= 1'b0;
    end else begin
      bclk_oe <= ~slave_mode;
      fclk_oe <= ~slave_mode;
    end
  end

  assign mclk_o  = out_a[0];
  assign bclk_o  = out_a[1];
  assign fclk_o  = out_a[2];
  assign sbclk_o = out_a[3];
  assign sfclk_o = out_a[4];

  // R6
  slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    slave_mode |=> (!bclk_oe && !fclk_oe && !bclk_o && !fclk_o));
endmodule

// File: tb/sim_audio_clk_gen.sv
module sim_audio_clk_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, pe = 1'b0, xe = 1'b0, lk = 1'b0, slv = 1'b0;
  logic phi = 1'b0, xhi = 1'b0;
  logic [1:0] pm = '0, xm = '0, xb = '0, xf = '0, psb = '0, psf = '0, xo = '0;
  logic mclk, bclk, boe, fclk, foe, sbclk, sfclk, xclk;

  audio_clk_gen u0 (
    .clk(clk), .rst(rst), .pll_edge(pe), .xtal_edge(xe), .pll_locked(lk),
    .slave_mode(slv), .pll_src_hi(phi), .xtal_src_hi(xhi),
    .pll_mclk_sel(pm), .xtal_mclk_sel(xm), .xtal_bclk_sel(xb), .xtal_fclk_sel(xf),
    .pll_sbclk_sel(psb), .pll_sfclk_sel(psf), .xout_sel(xo),
    .mclk_o(mclk), .bclk_o(bclk), .bclk_oe(boe), .fclk_o(fclk), .fclk_oe(foe),
    .sbclk_o(sbclk), .sfclk_o(sfclk), .xclk_o(xclk)
  );

  int checks = 0, errors = 0;
  int n = 0, nx = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s n=%0d actual=%0b expected=%0b", req, what, n, act, exp);
    end
  endtask

  function automatic logic bt(input int v, input int idx, input bit mute);
    return mute ? 1'b0 : 1'((v >>> idx) & 1);
  endfunction

  task automatic tick();
    @(negedge clk); pe = 1'b1; xe = 1'b1;
    @(negedge clk); pe = 1'b0; xe = 1'b0;
    @(negedge clk); n++; nx++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    n = 0; nx = 0;
  endtask

  initial begin
    logic pb, pf, psbv, psfv;
    // sweep over source, rate, selection and mode
    for (int i = 0; i < 8; i++) begin
      int s, h, eb, ef, esb, esf;
      bit loc, mu;
      loc = (i >= 4); h = (i >> 1) & 1; s = i & 3; mu = (s == 3);
      lk = loc; phi = 1'(h); xhi = 1'(h); slv = 1'(i & 1);
      pm = 2'(s); xm = 2'(s); xb = 2'(s); xf = 2'(s); psb = 2'(s); psf = 2'(s); xo = 2'(s);
      do_reset();
      // R10 reset state
      chk("R10", "mclk", mclk, 1'b0); chk("R10", "bclk", bclk, 1'b0);
      chk("R10", "fclk", fclk, 1'b0); chk("R10", "sbclk", sbclk, 1'b0);
      chk("R10", "sfclk", sfclk, 1'b0); chk("R10", "xclk", xclk, 1'b0);
      chk("R10", "bclk_oe", boe, ~slv); chk("R10", "fclk_oe", foe, ~slv);
      pb = 0; pf = 0; psbv = 0; psfv = 0;
      if (loc) begin eb = 2 + h; ef = 8 + h; esb = 1 + s + h; esf = 7 + s + h; end
      else begin eb = s + h; ef = 6 + s + h; esb = eb; esf = ef; end
      repeat (1100) begin
        tick();
        chk(loc ? "R2" : "R1", "mclk", mclk, bt(n, s, mu));
        chk(slv ? "R6" : "R3", "bclk", bclk, bt(n, eb, mu && !loc) & ~slv);
        chk(slv ? "R6" : "R3", "fclk", fclk, bt(n, ef, mu && !loc) & ~slv);
        chk("R4", "sbclk", sbclk, bt(n, esb, mu));
        chk("R4", "sfclk", sfclk, bt(n, esf, mu));
        chk("R5", "xclk", xclk, bt(nx, s, s >= 2));
        chk("R6", "bclk_oe", boe, ~slv);
        chk("R6", "fclk_oe", foe, ~slv);
        if (!slv && fclk !== pf) chk("R8", "frame vs bit fall", pb & ~bclk, 1'b1);
        if (sfclk !== psfv) chk("R8", "sframe vs sbit fall", psbv & ~sbclk, 1'b1);
        pb = bclk; pf = fclk; psbv = sbclk; psfv = sfclk;
      end
    end

    // R7: mute and rate change requested mid-high
    lk = 0; xhi = 0; phi = 0; slv = 0; xm = 0; xb = 0; xf = 2; xo = 0;
    do_reset();
    repeat (1700) begin
      logic e;
      tick();
      if (n <= 300)       e = bt(n, 8, 0);
      else if (n <= 1100) e = (n < 512) ? bt(n, 8, 0) : 1'b0;
      else if (n <= 1300) e = bt(n, 8, 0);
      else                e = (n < 1536) ? bt(n, 8, 0) : bt(n, 6, 0);
      chk("R7", "fclk", fclk, e);
      chk("R7", "sfclk", sfclk, e);
      if (n == 300)  xf = 2'd3;
      if (n == 1100) xf = 2'd2;
      if (n == 1300) xf = 2'd0;
    end

    // R9: lock changes with blanking and in-phase restart
    lk = 1; phi = 0; xhi = 0; pm = 0; psb = 0; psf = 0; xm = 0; xb = 0; xf = 0; xo = 0;
    do_reset();
    repeat (100) begin
      tick();
      chk("R2", "mclk locked", mclk, bt(n, 0, 0));
      chk("R3", "bclk locked", bclk, bt(n, 2, 0));
    end
    lk = 0;
    repeat (512) begin
      tick();
      chk("R9", "mclk blank", mclk, 1'b0); chk("R9", "bclk blank", bclk, 1'b0);
      chk("R9", "fclk blank", fclk, 1'b0); chk("R9", "sbclk blank", sbclk, 1'b0);
      chk("R9", "sfclk blank", sfclk, 1'b0);
      chk("R5", "xclk through switch", xclk, bt(nx, 0, 0));
    end
    n = 0;
    repeat (200) begin
      tick();
      chk("R9", "mclk restart", mclk, bt(n, 0, 0));
      chk("R9", "bclk restart", bclk, bt(n, 0, 0));
      chk("R9", "fclk restart", fclk, bt(n, 6, 0));
    end
    lk = 1; phi = 1;
    repeat (1024) begin
      tick();
      chk("R9", "mclk blank hi", mclk, 1'b0); chk("R9", "fclk blank hi", fclk, 1'b0);
      chk("R9", "sfclk blank hi", sfclk, 1'b0);
      chk("R5", "xclk through switch", xclk, bt(nx, 0, 0));
    end
    n = 0;
    repeat (600) begin
      tick();
      chk("R9", "mclk restart hi", mclk, bt(n, 0, 0));
      chk("R3", "bclk 512fs", bclk, bt(n, 3, 0));
      chk("R3", "fclk 512fs", fclk, bt(n, 9, 0));
      chk("R4", "sbclk 512fs", sbclk, bt(n, 2, 0));
      chk("R4", "sfclk 512fs", sfclk, bt(n, 8, 0));
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired n=%0d actual=running expected=done", n);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule